// File: doc/BRIEF.md
# Warm Reset Clock-Quiesce Sequencer

This block holds back a warm reset until two derived output clocks have been parked. A reset-side state machine accepts a warm-reset request. When the handshake enable input is high, it first asks a clock-producing unit to quiesce, and it drives warm reset only once that unit reports that both of its clocks have stopped. The clock-producing unit divides the core clock into a debug-port clock and an I/O configuration clock. It parks each clock only during its low phase, so no high pulse is ever cut short. It then answers with an acknowledge.

With the enable input low, the reset proceeds at once with no exchange, and the clocks keep running. A timeout bounds the wait for the acknowledge, so a request can never hang. The cold reset `rst` clears both sides at once. After the warm reset ends, the request drops, the acknowledge follows, and both clocks restart with a full low phase.

Top module: `wrst_quiesce_top`

## Requirements
- R1: While `rst` is high, `warm_rst_o`, `quiesce_req_o` and `quiesce_ack_o` are 0, both clock enables are 1 and both clock outputs are 0. All signals are active high.
- R2: With `hs_en_i`=1 at acceptance, `quiesce_req_o` is high for at least one cycle before `warm_rst_o` rises, and it is still high when `warm_rst_o` rises.
- R3: A clock enable falls only while its clock output is low. Every high phase of `dbg_clk_o` lasts exactly DBG_HALF cycles, and every high phase of `cfg_clk_o` lasts exactly CFG_HALF cycles.
- R4: `quiesce_ack_o` is high only while both enables and both clock outputs are low, and only if `quiesce_req_o` was high in the previous cycle.
- R5: In handshake mode with a timely acknowledge, `warm_rst_o` rises while `quiesce_ack_o` is high. This happens no earlier than the third edge after acceptance and no later than edge DBG_HALF+4.
- R6: If no acknowledge arrives, `warm_rst_o` rises on edge TIMEOUT+1 after acceptance, with `quiesce_ack_o` low.
- R7: With `hs_en_i`=0, the edge that samples `warm_req_i`=1 in idle also raises `warm_rst_o`. `quiesce_req_o` stays low and both enables stay 1.
- R8: Each warm-reset pulse lasts exactly RST_CYCLES cycles.
- R9: `quiesce_req_o` stays high for the whole warm-reset pulse and falls on the same edge as `warm_rst_o`.
- R10: One cycle after `quiesce_req_o` falls, `quiesce_ack_o` is 0 and both enables are 1 again.
- R11: `warm_req_i` is accepted only in idle. A request during a warm-reset pulse produces no further pulse, so each accepted request yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Cold reset, synchronous, active high, clears both sides |
| warm_req_i | input | 1 | Warm-reset request, sampled in idle |
| hs_en_i | input | 1 | Handshake enable control bit |
| warm_rst_o | output | 1 | Warm reset output |
| quiesce_req_o | output | 1 | Request to stop the derived clocks |
| quiesce_ack_o | output | 1 | Acknowledge that both clocks are parked |
| dbg_clk_o | output | 1 | Derived debug-port clock |
| cfg_clk_o | output | 1 | Derived I/O configuration clock |
| dbg_clk_en_o | output | 1 | Debug-port clock running |
| cfg_clk_en_o | output | 1 | I/O configuration clock running |

## Verification
The timeout path is the hard case to reach. The acknowledge comes from the block's own clock unit, so it cannot be withheld from the ports. The stimulus uses the slow configuration clock: its default half period is longer than the timeout. A request made just after that clock rises therefore waits for a low phase that cannot arrive in time. The other handshake runs are aligned to a fresh low phase of the configuration clock, once with the debug clock low and once just after it rises, so parking waits on the fast clock alone. A second request is pulsed while the warm reset is active.

// File: rtl/wrq_pkg.sv
package wrq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_ACK,
        ST_RESET,
        ST_RELEASE
    } wrq_state_e;

    // status of one derived clock
    typedef struct packed {
        logic lvl;   // clock output level
        logic en;    // clock generation running
    } gate_stat_t;

    localparam int NUM_CLK = 2;
    localparam int CLK_DBG = 0;
    localparam int CLK_CFG = 1;

    // counter width that holds 0 .. n-1, at least one bit
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wrq_sequencer.sv
module wrq_sequencer
    import wrq_pkg::*;
#(
    parameter int TIMEOUT    = 64,
    parameter int RST_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic warm_req_i,
    input  logic hs_en_i,
    input  logic ack_i,
    output logic q_req_o,
    output logic warm_rst_o
);
    localparam int TW = cnt_width(TIMEOUT);
    localparam int RW = cnt_width(RST_CYCLES);

    wrq_state_e    state;
    logic          hs_used;
    logic [TW-1:0] tmr;
    logic [RW-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            hs_used <= 1'b0;
            tmr     <= '0;
            rcnt    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    rcnt <= '0;
                    tmr  <= '0;
                    if (warm_req_i) begin
                        hs_used <= hs_en_i;
                        state   <= hs_en_i ? ST_REQ : ST_RESET;
                    end
                end
                ST_REQ: begin
                    tmr   <= '0;
                    state <= ST_WAIT_ACK;
                end
                ST_WAIT_ACK: begin
                    if (ack_i || tmr == TW'(TIMEOUT - 1)) begin
                        rcnt  <= '0;
                        state <= ST_RESET;
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                ST_RESET: begin
                    if (rcnt == RW'(RST_CYCLES - 1)) begin
                        state <= ST_RELEASE;
                    end else begin
                        rcnt <= rcnt + 1'b1;
                    end
                end
                ST_RELEASE: begin
                    if (!ack_i) begin
                        hs_used <= 1'b0;
                        state   <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        warm_rst_o = (state == ST_RESET);
        q_req_o    = hs_used &&
                     (state == ST_REQ || state == ST_WAIT_ACK || state == ST_RESET);
    end

endmodule

// File: rtl/wrq_clk_gate.sv
module wrq_clk_gate
    import wrq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run_i,
    output gate_stat_t stat_o
);
    localparam int CW = cnt_width(HALF);

    logic          active;
    logic          lvl;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b1;
            lvl    <= 1'b0;
            cnt    <= '0;
        end else if (active) begin
            if (!run_i && !lvl) begin
                // park only in the low phase
                active <= 1'b0;
                cnt    <= '0;
            end else if (cnt == CW'(HALF - 1)) begin
                cnt <= '0;
                lvl <= ~lvl;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (run_i) begin
            active <= 1'b1;
            cnt    <= '0;
        end
    end

    assign stat_o = '{lvl: lvl, en: active};

endmodule

// File: rtl/wrq_quiesce_unit.sv
module wrq_quiesce_unit
    import wrq_pkg::*;
#(
    parameter int DBG_HALF = 2,
    parameter int CFG_HALF = 80
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_i,
    output logic               ack_o,
    output logic [NUM_CLK-1:0] lvl_o,
    output logic [NUM_CLK-1:0] en_o
);
    gate_stat_t stat [NUM_CLK];

    for (genvar g = 0; g < NUM_CLK; g++) begin : g_clk
        localparam int HALF = (g == CLK_DBG) ? DBG_HALF : CFG_HALF;
        wrq_clk_gate #(.HALF(HALF)) u_gate (
            .clk    (clk),
            .rst    (rst),
            .run_i  (!req_i),
            .stat_o (stat[g])
        );
        assign lvl_o[g] = stat[g].lvl;
        assign en_o[g]  = stat[g].en;
    end

    always_ff @(posedge clk) begin
        if (rst) ack_o <= 1'b0;
        else     ack_o <= req_i && !(|en_o);
    end

endmodule

// File: rtl/wrst_quiesce_top.sv
module wrst_quiesce_top
    import wrq_pkg::*;
#(
    parameter int TIMEOUT    = 64,
    parameter int RST_CYCLES = 4,
    parameter int DBG_HALF   = 2,
    parameter int CFG_HALF   = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic warm_req_i,
    input  logic hs_en_i,
    output logic warm_rst_o,
    output logic quiesce_req_o,
    output logic quiesce_ack_o,
    output logic dbg_clk_o,
    output logic cfg_clk_o,
    output logic dbg_clk_en_o,
    output logic cfg_clk_en_o
);
    logic [NUM_CLK-1:0] lvl;
    logic [NUM_CLK-1:0] en;

    wrq_sequencer #(.TIMEOUT(TIMEOUT), .RST_CYCLES(RST_CYCLES)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .warm_req_i (warm_req_i),
        .hs_en_i    (hs_en_i),
        .ack_i      (quiesce_ack_o),
        .q_req_o    (quiesce_req_o),
        .warm_rst_o (warm_rst_o)
    );

    wrq_quiesce_unit #(.DBG_HALF(DBG_HALF), .CFG_HALF(CFG_HALF)) u_quiesce (
        .clk   (clk),
        .rst   (rst),
        .req_i (quiesce_req_o),
        .ack_o (quiesce_ack_o),
        .lvl_o (lvl),
        .en_o  (en)
    );

    assign dbg_clk_o    = lvl[CLK_DBG];
    assign cfg_clk_o    = lvl[CLK_CFG];
    assign dbg_clk_en_o = en[CLK_DBG];
    assign cfg_clk_en_o = en[CLK_CFG];

endmodule

// File: rtl/wrst_quiesce_chk.sv
module wrst_quiesce_chk #(
    parameter int TIMEOUT    = 64,
    parameter int RST_CYCLES = 4,
    parameter int DBG_HALF   = 2,
    parameter int CFG_HALF   = 80
) (
    input logic clk,
    input logic rst,
    input logic warm_req_i,
    input logic hs_en_i,
    input logic warm_rst_o,
    input logic quiesce_req_o,
    input logic quiesce_ack_o,
    input logic dbg_clk_o,
    input logic cfg_clk_o,
    input logic dbg_clk_en_o,
    input logic cfg_clk_en_o
);
    int req_cnt;
    int rst_cnt;
    int dbg_hi;
    int cfg_hi;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_cnt <= 0;
            rst_cnt <= 0;
            dbg_hi  <= 0;
            cfg_hi  <= 0;
        end else begin
            if (!quiesce_req_o)   req_cnt <= 0;
            else if (!warm_rst_o) req_cnt <= req_cnt + 1;
            rst_cnt <= warm_rst_o ? rst_cnt + 1 : 0;
            dbg_hi  <= dbg_clk_o ? dbg_hi + 1 : 0;
            cfg_hi  <= cfg_clk_o ? cfg_hi + 1 : 0;
        end
    end

    AST_REQ_BEFORE_RST: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_rst_o) && quiesce_req_o |-> $past(quiesce_req_o)); // R2
    AST_DBG_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_clk_en_o) |-> !dbg_clk_o); // R3
    AST_CFG_STOP_LOW: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_clk_en_o) |-> !cfg_clk_o); // R3
    AST_DBG_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(dbg_clk_o) |-> dbg_hi == DBG_HALF); // R3
    AST_CFG_HIGH_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(cfg_clk_o) |-> cfg_hi == CFG_HALF); // R3
    AST_ACK_PARKED: assert property (@(posedge clk) disable iff (rst)
        quiesce_ack_o |-> !dbg_clk_en_o && !cfg_clk_en_o && !dbg_clk_o && !cfg_clk_o); // R4
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(quiesce_ack_o) |-> $past(quiesce_req_o)); // R4
    AST_RST_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_rst_o) && quiesce_req_o && req_cnt <= TIMEOUT |-> quiesce_ack_o); // R5
    AST_TIMEOUT_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_rst_o) && quiesce_req_o && !quiesce_ack_o |-> req_cnt == TIMEOUT + 1); // R6
    AST_BYPASS: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_rst_o) && !quiesce_req_o |-> $past(warm_req_i) && !$past(hs_en_i)); // R7
    AST_RST_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(warm_rst_o) |-> rst_cnt == RST_CYCLES); // R8
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(quiesce_req_o) |-> $fell(warm_rst_o)); // R9
    AST_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
        $fell(quiesce_req_o) |=> !quiesce_ack_o); // R10
    AST_CLK_RESTART: assert property (@(posedge clk) disable iff (rst)
        !quiesce_req_o && !quiesce_ack_o |=> dbg_clk_en_o && cfg_clk_en_o); // R10

endmodule

bind wrst_quiesce_top wrst_quiesce_chk #(
    .TIMEOUT    (TIMEOUT),
    .RST_CYCLES (RST_CYCLES),
    .DBG_HALF   (DBG_HALF),
    .CFG_HALF   (CFG_HALF)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .warm_req_i    (warm_req_i),
    .hs_en_i       (hs_en_i),
    .warm_rst_o    (warm_rst_o),
    .quiesce_req_o (quiesce_req_o),
    .quiesce_ack_o (quiesce_ack_o),
    .dbg_clk_o     (dbg_clk_o),
    .cfg_clk_o     (cfg_clk_o),
    .dbg_clk_en_o  (dbg_clk_en_o),
    .cfg_clk_en_o  (cfg_clk_en_o)
);

// File: tb/wrst_quiesce_top_test.sv
module wrst_quiesce_top_test;
    localparam int TIMEOUT    = 64;
    localparam int RST_CYCLES = 4;
    localparam int DBG_HALF   = 2;
    localparam int CFG_HALF   = 80;

    localparam int K_BYPASS  = 0;
    localparam int K_ACK     = 1;
    localparam int K_TIMEOUT = 2;

    typedef struct {
        int kind;
        int stamp;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic warm_req_i = 1'b0;
    logic hs_en_i = 1'b0;
    logic warm_rst_o, quiesce_req_o, quiesce_ack_o;
    logic dbg_clk_o, cfg_clk_o, dbg_clk_en_o, cfg_clk_en_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rises = 0;
    bit finished = 1'b0;
    exp_t exp_q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wrst_quiesce_top #(
        .TIMEOUT(TIMEOUT), .RST_CYCLES(RST_CYCLES),
        .DBG_HALF(DBG_HALF), .CFG_HALF(CFG_HALF)
    ) uut (
        .clk(clk), .rst(rst), .warm_req_i(warm_req_i), .hs_en_i(hs_en_i),
        .warm_rst_o(warm_rst_o), .quiesce_req_o(quiesce_req_o),
        .quiesce_ack_o(quiesce_ack_o), .dbg_clk_o(dbg_clk_o),
        .cfg_clk_o(cfg_clk_o), .dbg_clk_en_o(dbg_clk_en_o),
        .cfg_clk_en_o(cfg_clk_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // driver: one-cycle request, expected outcome pushed to the scoreboard
    task automatic issue(input int kind, input bit hs);
        @(negedge clk);
        hs_en_i    = hs;
        warm_req_i = 1'b1;
        exp_q.push_back('{kind: kind, stamp: cyc});
        @(negedge clk);
        warm_req_i = 1'b0;
    endtask

    task automatic wait_cfg_fall();
        while (cfg_clk_o !== 1'b1) @(negedge clk);
        while (cfg_clk_o !== 1'b0) @(negedge clk);
    endtask

    // monitor
    bit prev_w = 1'b0;
    bit ack_chk = 1'b0;
    int rise_cyc = 0;
    always @(negedge clk) begin
        if (rst) begin
            prev_w  = 1'b0;
            ack_chk = 1'b0;
        end else begin
            if (ack_chk) begin
                chk(quiesce_ack_o == 1'b0, "R10 ack dropped", int'(quiesce_ack_o), 0);
                chk(dbg_clk_en_o && cfg_clk_en_o, "R10 clocks restarted",
                    int'({dbg_clk_en_o, cfg_clk_en_o}), 3);
                ack_chk = 1'b0;
            end
            if (warm_rst_o && !prev_w) begin
                rises++;
                rise_cyc = cyc;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected warm reset", 1, 0);
                end else begin
                    exp_t e;
                    int lat;
                    e   = exp_q.pop_front();
                    lat = cyc - e.stamp;
                    case (e.kind)
                        K_BYPASS: begin
                            chk(lat == 1, "R7 bypass latency", lat, 1);
                            chk(!quiesce_req_o, "R7 no request", int'(quiesce_req_o), 0);
                            chk(dbg_clk_en_o && cfg_clk_en_o, "R7 clocks running",
                                int'({dbg_clk_en_o, cfg_clk_en_o}), 3);
                        end
                        K_ACK: begin
                            chk(quiesce_req_o, "R2 request held at reset", int'(quiesce_req_o), 1);
                            chk(quiesce_ack_o, "R5 ack present", int'(quiesce_ack_o), 1);
                            chk(lat >= 4 && lat <= DBG_HALF + 5, "R5 handshake latency", lat, 4);
                            chk(!dbg_clk_en_o && !cfg_clk_en_o && !dbg_clk_o && !cfg_clk_o,
                                "R4 clocks parked",
                                int'({dbg_clk_en_o, cfg_clk_en_o, dbg_clk_o, cfg_clk_o}), 0);
                        end
                        default: begin
                            chk(lat == TIMEOUT + 2, "R6 timeout latency", lat, TIMEOUT + 2);
                            chk(quiesce_req_o, "R2 request held at timeout", int'(quiesce_req_o), 1);
                            chk(!quiesce_ack_o, "R6 no ack", int'(quiesce_ack_o), 0);
                        end
                    endcase
                end
            end
            if (!warm_rst_o && prev_w) begin
                chk(cyc - rise_cyc == RST_CYCLES, "R8 pulse width", cyc - rise_cyc, RST_CYCLES);
                chk(!quiesce_req_o, "R9 request drops with reset", int'(quiesce_req_o), 0);
                ack_chk = 1'b1;
            end
            prev_w = warm_rst_o;
        end
    end

    // watchdog
    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!warm_rst_o && !quiesce_req_o && !quiesce_ack_o, "R1 outputs low",
            int'({warm_rst_o, quiesce_req_o, quiesce_ack_o}), 0);
        chk(dbg_clk_en_o && cfg_clk_en_o, "R1 enables high",
            int'({dbg_clk_en_o, cfg_clk_en_o}), 3);
        chk(!dbg_clk_o && !cfg_clk_o, "R1 clocks low", int'({dbg_clk_o, cfg_clk_o}), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // R7 bypass
        issue(K_BYPASS, 1'b0);
        repeat (20) @(negedge clk);

        // R5 handshake, fresh configuration low phase
        wait_cfg_fall();
        issue(K_ACK, 1'b1);
        repeat (40) @(negedge clk);

        // R6 timeout: configuration clock just rose, its high phase outlasts the wait
        while (cfg_clk_o !== 1'b1) @(negedge clk);
        issue(K_TIMEOUT, 1'b1);
        repeat (120) @(negedge clk);

        // R3 handshake with debug clock just risen
        wait_cfg_fall();
        while (dbg_clk_o !== 1'b0) @(negedge clk);
        while (dbg_clk_o !== 1'b1) @(negedge clk);
        issue(K_ACK, 1'b1);
        repeat (40) @(negedge clk);

        // R11 second request during the warm-reset pulse
        wait_cfg_fall();
        issue(K_ACK, 1'b1);
        while (warm_rst_o !== 1'b1) @(negedge clk);
        hs_en_i    = 1'b1;
        warm_req_i = 1'b1;
        @(negedge clk);
        warm_req_i = 1'b0;
        repeat (150) @(negedge clk);

        chk(exp_q.size() == 0, "R11 scoreboard drained", exp_q.size(), 0);
        chk(rises == 5, "R11 one pulse per accepted request", rises, 5);
        chk(!warm_rst_o && !quiesce_req_o, "R11 idle at end",
            int'({warm_rst_o, quiesce_req_o}), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule